// File: doc/BRIEF.md
# IOMMU Tagged Translation Cache

This block keeps recently walked IO virtual to physical page translations close to the IOMMU datapath. Every slot carries the page pair, a 2-bit access permission and two context tags: a guest context ID and a process context ID. A device request is looked up combinationally. On a hit, the physical address and permission come back in the same cycle. On a miss, the page-table walker resolves the request and then offers the result on the fill port. The fill is accepted only if the walk succeeded, the result is not an identity mapping, and the result was not sent to the message-signalled-interrupt trap path.

Software keeps the cache coherent through decoded invalidation commands of two kinds. The first-stage (VMA) kind is scoped by guest ID, process ID and page. The second-stage (GVMA) kind is scoped by guest ID only. Invalidation never frees a slot. It only downgrades the slot's permission to none. An entry limit input caps occupancy. When the limit is reached, the whole cache is emptied before the new entry goes in.

Top module: `xtc_cache`

## Requirements
- R1: After reset, no lookup hits, and `inv_done` and `inv_illegal` are low.
- R2: A lookup hits only when a valid slot matches all three tags (guest ID, process ID and page number `lk_vaddr[55:12]`) and the slot's permission is not none. Permission encoding: 2'b00 means none, bit 0 means read, bit 1 means write. On a hit, `lk_paddr` is the stored page concatenated with `lk_vaddr[11:0]`, and `lk_perm` is the stored permission. A mismatch on any single tag misses.
- R3: A fill is written at the clock edge and is visible from the next cycle. It is written only when `fill_ok` is 1, `fill_trap` is 0 and `fill_vaddr` differs from `fill_paddr`. Otherwise it is dropped.
- R4: While `cfg_limit` is 0, every fill is dropped.
- R5: Occupancy counts every slot that was ever filled since the last flush, including invalidated slots. If occupancy is at or above `cfg_limit`, or no slot is free, when a fill is taken, then all slots are emptied first and the new entry is stored alone.
- R6: A fill whose three tags equal those of an occupied slot overwrites that slot in place and does not raise occupancy.
- R7: A VMA invalidate (`inv_gvma`=0) selects its match mode as follows. With gv=0 it kills every slot. With gv=1 and pscv=0 it kills slots whose guest ID matches. With gv=1, pscv=1 and av=0 it kills slots whose guest and process IDs match. With gv, pscv and av all 1 it also requires the page to match.
- R8: A GVMA invalidate (`inv_gvma`=1) with pscv=0 kills every slot when gv=0. When gv=1 it kills slots whose guest ID matches, and av and the address have no effect.
- R9: A GVMA invalidate with pscv=1 is illegal. It kills nothing, and `inv_illegal` is raised together with `inv_done`.
- R10: `inv_done` is high for exactly the cycle after each cycle in which `inv_valid` is high.
- R11: A lookup in the same cycle as an invalidation already sees that invalidation's effect.
- R12: If a fill and an invalidation arrive in the same cycle, the invalidation is applied first, so the new entry survives.
- R13: Bits [11:0] of `inv_addr` are ignored in page matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_limit | input | 4 | Maximum occupancy before a flush |
| lk_vaddr | input | 56 | Lookup IO virtual address |
| lk_gid | input | 16 | Lookup guest context ID |
| lk_pid | input | 20 | Lookup process context ID |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | 56 | Translated address on hit |
| lk_perm | output | 2 | Permission on hit |
| fill_valid | input | 1 | Walker offers a result |
| fill_ok | input | 1 | Walk completed without fault |
| fill_trap | input | 1 | Result was routed to the interrupt trap path |
| fill_vaddr | input | 56 | Walked IO virtual address |
| fill_paddr | input | 56 | Walked physical address |
| fill_gid | input | 16 | Guest context ID of the walk |
| fill_pid | input | 20 | Process context ID of the walk |
| fill_perm | input | 2 | Permission from the walk |
| inv_valid | input | 1 | Invalidation command strobe |
| inv_gvma | input | 1 | 1 selects second-stage scope, 0 first-stage scope |
| inv_gv | input | 1 | Guest ID qualifier valid |
| inv_pscv | input | 1 | Process ID qualifier valid |
| inv_av | input | 1 | Address qualifier valid |
| inv_gid | input | 16 | Guest ID to match |
| inv_pid | input | 20 | Process ID to match |
| inv_addr | input | 56 | Address to match |
| inv_done | output | 1 | Command completed |
| inv_illegal | output | 1 | Completed command had an illegal argument combination |

## Verification
On every cycle, the assertions check the timing of the completion pulse, that an illegal flag never appears without completion, that no hit carries a none permission, that a taken fill always leaves the cache non-empty, and that a zero limit never lets occupancy grow. Only the bench scenarios can show the following: which slots each invalidation mode spares, that the address offset is ignored, that a flush happens at exactly the configured limit, that a duplicate tag is overwritten in place, and the ordering of a fill or lookup issued alongside an invalidation.

// File: rtl/xtc_pkg.sv
package xtc_pkg;
    parameter int VPN_W = 44;
    parameter int PPN_W = 44;
    parameter int GID_W = 16;
    parameter int PID_W = 20;
    parameter int OFF_W = 12;
    localparam int VA_W = VPN_W + OFF_W;
    localparam int PA_W = PPN_W + OFF_W;

    typedef logic [1:0] perm_t;
    localparam perm_t PERM_NONE = 2'b00;

    typedef enum logic [2:0] {
        INV_NONE,
        INV_ALL,
        INV_GID,
        INV_GID_PID,
        INV_GID_PID_VPN
    } inv_mode_e;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PID_W-1:0] pid;
        logic [PPN_W-1:0] ppn;
        logic [GID_W-1:0] gid;
        perm_t            perm;
    } entry_t;
endpackage

// File: rtl/xtc_inv_decode.sv
module xtc_inv_decode
    import xtc_pkg::*;
(
    input  logic      inv_valid,
    input  logic      is_gvma,
    input  logic      gv,
    input  logic      pscv,
    input  logic      av,
    output inv_mode_e mode,
    output logic      illegal
);
    always_comb begin
        mode    = INV_NONE;
        illegal = 1'b0;
        if (inv_valid) begin
            if (is_gvma) begin
                if (pscv)     illegal = 1'b1;
                else if (!gv) mode    = INV_ALL;
                else          mode    = INV_GID;
            end else begin
                if (!gv)        mode = INV_ALL;
                else if (!pscv) mode = INV_GID;
                else if (!av)   mode = INV_GID_PID;
                else            mode = INV_GID_PID_VPN;
            end
        end
    end
endmodule

// File: rtl/xtc_entry_cmp.sv
module xtc_entry_cmp
    import xtc_pkg::*;
(
    input  logic             e_valid,
    input  logic [VPN_W-1:0] e_vpn,
    input  logic [GID_W-1:0] e_gid,
    input  logic [PID_W-1:0] e_pid,
    input  perm_t            e_perm,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [GID_W-1:0] lk_gid,
    input  logic [PID_W-1:0] lk_pid,
    input  inv_mode_e        mode,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic [GID_W-1:0] inv_gid,
    input  logic [PID_W-1:0] inv_pid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [GID_W-1:0] fill_gid,
    input  logic [PID_W-1:0] fill_pid,
    output logic             lk_live,
    output logic             inv_kill,
    output logic             fill_same
);
    logic g_eq, p_eq, v_eq;

    assign g_eq = (e_gid == inv_gid);
    assign p_eq = (e_pid == inv_pid);
    assign v_eq = (e_vpn == inv_vpn);

    assign lk_live = e_valid && (e_perm != PERM_NONE) && (e_gid == lk_gid)
                     && (e_pid == lk_pid) && (e_vpn == lk_vpn);

    assign fill_same = e_valid && (e_gid == fill_gid) && (e_pid == fill_pid)
                       && (e_vpn == fill_vpn);

    always_comb begin
        case (mode)
            INV_ALL:         inv_kill = e_valid;
            INV_GID:         inv_kill = e_valid && g_eq;
            INV_GID_PID:     inv_kill = e_valid && g_eq && p_eq;
            INV_GID_PID_VPN: inv_kill = e_valid && g_eq && p_eq && v_eq;
            default:         inv_kill = 1'b0;
        endcase
    end
endmodule

// File: rtl/xtc_alloc.sv
module xtc_alloc #(
    parameter int N = 8,
    localparam int CNT_W = $clog2(N + 1),
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     used,
    output logic [CNT_W-1:0] occ,
    output logic             free_any,
    output logic [IDX_W-1:0] free_idx
);
    always_comb begin
        occ      = '0;
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            occ = occ + CNT_W'(used[i]);
            if (!used[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/xtc_cache.sv
module xtc_cache
    import xtc_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int CNT_W = $clog2(ENTRIES + 1),
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_limit,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [GID_W-1:0] lk_gid,
    input  logic [PID_W-1:0] lk_pid,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_paddr,
    output logic [1:0]       lk_perm,
    input  logic             fill_valid,
    input  logic             fill_ok,
    input  logic             fill_trap,
    input  logic [VA_W-1:0]  fill_vaddr,
    input  logic [PA_W-1:0]  fill_paddr,
    input  logic [GID_W-1:0] fill_gid,
    input  logic [PID_W-1:0] fill_pid,
    input  logic [1:0]       fill_perm,
    input  logic             inv_valid,
    input  logic             inv_gvma,
    input  logic             inv_gv,
    input  logic             inv_pscv,
    input  logic             inv_av,
    input  logic [GID_W-1:0] inv_gid,
    input  logic [PID_W-1:0] inv_pid,
    input  logic [VA_W-1:0]  inv_addr,
    output logic             inv_done,
    output logic             inv_illegal
);
    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic                 done;
        logic                 illegal;
    } state_t;

    state_t s_d, s_q;

    inv_mode_e          mode;
    logic               inv_bad;
    logic [ENTRIES-1:0] live_vec, kill_vec, same_vec, used_vec;
    logic [CNT_W-1:0]   occ;
    logic               free_any;
    logic [IDX_W-1:0]   free_idx;
    logic               fill_take;
    logic               same_any;
    logic [IDX_W-1:0]   same_idx;
    entry_t             new_ent;
    logic               unused_inv_off;

    assign unused_inv_off = ^inv_addr[OFF_W-1:0];

    xtc_inv_decode u_dec (
        .inv_valid (inv_valid),
        .is_gvma   (inv_gvma),
        .gv        (inv_gv),
        .pscv      (inv_pscv),
        .av        (inv_av),
        .mode      (mode),
        .illegal   (inv_bad)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign used_vec[g] = s_q.ent[g].valid;
        xtc_entry_cmp u_cmp (
            .e_valid   (s_q.ent[g].valid),
            .e_vpn     (s_q.ent[g].vpn),
            .e_gid     (s_q.ent[g].gid),
            .e_pid     (s_q.ent[g].pid),
            .e_perm    (s_q.ent[g].perm),
            .lk_vpn    (lk_vaddr[VA_W-1:OFF_W]),
            .lk_gid    (lk_gid),
            .lk_pid    (lk_pid),
            .mode      (mode),
            .inv_vpn   (inv_addr[VA_W-1:OFF_W]),
            .inv_gid   (inv_gid),
            .inv_pid   (inv_pid),
            .fill_vpn  (fill_vaddr[VA_W-1:OFF_W]),
            .fill_gid  (fill_gid),
            .fill_pid  (fill_pid),
            .lk_live   (live_vec[g]),
            .inv_kill  (kill_vec[g]),
            .fill_same (same_vec[g])
        );
    end

    xtc_alloc #(.N(ENTRIES)) u_alloc (
        .used     (used_vec),
        .occ      (occ),
        .free_any (free_any),
        .free_idx (free_idx)
    );

    assign fill_take = fill_valid && fill_ok && !fill_trap
                       && (PA_W'(fill_vaddr) != fill_paddr)
                       && (cfg_limit != '0);

    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.vpn   = fill_vaddr[VA_W-1:OFF_W];
        new_ent.ppn   = fill_paddr[PA_W-1:OFF_W];
        new_ent.gid   = fill_gid;
        new_ent.pid   = fill_pid;
        new_ent.perm  = fill_perm;
    end

    always_comb begin
        same_any = 1'b0;
        same_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (same_vec[i]) begin
                same_any = 1'b1;
                same_idx = IDX_W'(i);
            end
        end
    end

    // Lookup sees the state after a same-cycle invalidation.
    always_comb begin
        lk_hit   = 1'b0;
        lk_paddr = '0;
        lk_perm  = PERM_NONE;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (live_vec[i] && !kill_vec[i]) begin
                lk_hit   = 1'b1;
                lk_paddr = {s_q.ent[i].ppn, lk_vaddr[OFF_W-1:0]};
                lk_perm  = s_q.ent[i].perm;
            end
        end
    end

    always_comb begin
        s_d         = s_q;
        s_d.done    = inv_valid;
        s_d.illegal = inv_bad;
        for (int i = 0; i < ENTRIES; i++) begin
            if (kill_vec[i]) s_d.ent[i].perm = PERM_NONE;
        end
        if (fill_take) begin
            if (same_any) begin
                s_d.ent[same_idx] = new_ent;
            end else if ((occ >= cfg_limit) || !free_any) begin
                for (int i = 0; i < ENTRIES; i++) s_d.ent[i].valid = 1'b0;
                s_d.ent[0] = new_ent;
            end else begin
                s_d.ent[free_idx] = new_ent;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign inv_done    = s_q.done;
    assign inv_illegal = s_q.illegal;
endmodule

// File: rtl/xtc_cache_chk.sv
module xtc_cache_chk #(
    parameter int ENTRIES = 8,
    localparam int CNT_W = $clog2(ENTRIES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inv_valid,
    input logic             inv_done,
    input logic             inv_illegal,
    input logic             lk_hit,
    input logic [1:0]       lk_perm,
    input logic             fill_take,
    input logic [CNT_W-1:0] occ,
    input logic [CNT_W-1:0] cfg_limit
);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |=> inv_done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_valid |=> !inv_done);

    p_illegal_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        inv_illegal |-> inv_done);

    p_hit_perm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_perm != 2'b00));

    p_fill_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_take |=> (occ != '0));

    p_limit_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_limit == '0) |=> (occ <= $past(occ)));
endmodule

bind xtc_cache xtc_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .inv_valid   (inv_valid),
    .inv_done    (inv_done),
    .inv_illegal (inv_illegal),
    .lk_hit      (lk_hit),
    .lk_perm     (lk_perm),
    .fill_take   (fill_take),
    .occ         (occ),
    .cfg_limit   (cfg_limit)
);

// File: tb/xtc_cache_test.sv
module xtc_cache_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_limit = 4'd8;
    logic [55:0] lk_vaddr = '0;
    logic [15:0] lk_gid = '0;
    logic [19:0] lk_pid = '0;
    logic        lk_hit;
    logic [55:0] lk_paddr;
    logic [1:0]  lk_perm;
    logic        fill_valid = 0, fill_ok = 0, fill_trap = 0;
    logic [55:0] fill_vaddr = '0, fill_paddr = '0;
    logic [15:0] fill_gid = '0;
    logic [19:0] fill_pid = '0;
    logic [1:0]  fill_perm = '0;
    logic        inv_valid = 0, inv_gvma = 0, inv_gv = 0, inv_pscv = 0, inv_av = 0;
    logic [15:0] inv_gid = '0;
    logic [19:0] inv_pid = '0;
    logic [55:0] inv_addr = '0;
    logic        inv_done, inv_illegal;

    int checks = 0;
    int fails = 0;
    bit alive [6];
    logic [43:0] ppn_e [6];
    logic [1:0]  perm_e [6];

    always #5 clk = ~clk;

    xtc_cache uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic look(input logic [43:0] vpn, input logic [11:0] off,
                        input logic [15:0] gid, input logic [19:0] pid,
                        input bit eh, input logic [43:0] eppn,
                        input logic [1:0] eperm, input string req);
        lk_vaddr = {vpn, off};
        lk_gid = gid;
        lk_pid = pid;
        #1;
        chk(lk_hit == eh, req, "hit", 64'(lk_hit), 64'(eh));
        if (eh) begin
            chk(lk_paddr == {eppn, off}, req, "paddr", 64'(lk_paddr), 64'({eppn, off}));
            chk(lk_perm == eperm, req, "perm", 64'(lk_perm), 64'(eperm));
        end
    endtask

    task automatic fill(input logic [43:0] vpn, input logic [43:0] ppn,
                        input logic [15:0] gid, input logic [19:0] pid,
                        input logic [1:0] perm, input bit ok, input bit trap);
        @(negedge clk);
        fill_valid = 1; fill_ok = ok; fill_trap = trap;
        fill_vaddr = {vpn, 12'h0}; fill_paddr = {ppn, 12'h0};
        fill_gid = gid; fill_pid = pid; fill_perm = perm;
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic inv(input bit gvma, input bit gv, input bit pscv, input bit av,
                       input logic [15:0] gid, input logic [19:0] pid,
                       input logic [55:0] addr, input bit eill, input string req);
        @(negedge clk);
        inv_valid = 1; inv_gvma = gvma; inv_gv = gv; inv_pscv = pscv; inv_av = av;
        inv_gid = gid; inv_pid = pid; inv_addr = addr;
        @(negedge clk);
        inv_valid = 0;
        chk(inv_done == 1'b1, "R10", "done", 64'(inv_done), 64'd1);
        chk(inv_illegal == eill, req, "illegal", 64'(inv_illegal), 64'(eill));
        @(negedge clk);
        chk(inv_done == 1'b0, "R10", "done clears", 64'(inv_done), 64'd0);
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < 6; i++)
            look(44'(i + 16), 12'(i * 37), 16'(i & 1), 20'(i >> 1),
                 alive[i], ppn_e[i], perm_e[i], req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(inv_done == 0, "R1", "done", 64'(inv_done), 0);
        chk(inv_illegal == 0, "R1", "illegal", 64'(inv_illegal), 0);
        look(44'd16, 12'h0, 16'd0, 20'd0, 0, 0, 0, "R1");

        // R2/R3 populate six slots
        for (int i = 0; i < 6; i++) begin
            alive[i] = 1;
            ppn_e[i] = 44'(i + 'h200);
            perm_e[i] = 2'((i % 3) + 1);
            fill(44'(i + 16), ppn_e[i], 16'(i & 1), 20'(i >> 1), perm_e[i], 1, 0);
        end
        sweep("R2");
        look(44'd16, 12'h5, 16'd1, 20'd0, 0, 0, 0, "R2 gid mismatch");
        look(44'd16, 12'h5, 16'd0, 20'd1, 0, 0, 0, "R2 pid mismatch");
        look(44'd99, 12'h5, 16'd0, 20'd0, 0, 0, 0, "R2 page mismatch");

        // R3 gating
        fill(44'd40, 44'h500, 16'd0, 20'd0, 2'd3, 0, 0);
        look(44'd40, 12'h0, 16'd0, 20'd0, 0, 0, 0, "R3 fault");
        fill(44'd41, 44'h501, 16'd0, 20'd0, 2'd3, 1, 1);
        look(44'd41, 12'h0, 16'd0, 20'd0, 0, 0, 0, "R3 trap");
        fill(44'd42, 44'd42, 16'd0, 20'd0, 2'd3, 1, 0);
        look(44'd42, 12'h0, 16'd0, 20'd0, 0, 0, 0, "R3 identity");

        // R6 overwrite in place
        ppn_e[0] = 44'h300; perm_e[0] = 2'd3;
        fill(44'd16, 44'h300, 16'd0, 20'd0, 2'd3, 1, 0);
        sweep("R6");

        // R7 + R13: full-match VMA with a nonzero offset
        inv(0, 1, 1, 1, 16'd1, 20'd0, {44'd17, 12'hABC}, 0, "R13");
        for (int i = 0; i < 6; i++)
            if ((i & 1) == 1 && (i >> 1) == 0 && i + 16 == 17) alive[i] = 0;
        sweep("R7 R13 page");

        // R7 guest+process
        inv(0, 1, 1, 0, 16'd0, 20'd1, 56'h0, 0, "R7");
        for (int i = 0; i < 6; i++)
            if ((i & 1) == 0 && (i >> 1) == 1) alive[i] = 0;
        sweep("R7 gid pid");

        // R9 illegal GVMA
        inv(1, 1, 1, 0, 16'd0, 20'd0, 56'h0, 1, "R9");
        sweep("R9 no kill");

        // R8 guest-only GVMA, av ignored
        inv(1, 1, 0, 1, 16'd1, 20'd0, {44'd999, 12'h0}, 0, "R8");
        for (int i = 0; i < 6; i++)
            if ((i & 1) == 1) alive[i] = 0;
        sweep("R8 gid");

        // R7 guest-only VMA
        inv(0, 1, 0, 1, 16'd0, 20'd7, 56'h0, 0, "R7");
        for (int i = 0; i < 6; i++)
            if ((i & 1) == 0) alive[i] = 0;
        sweep("R7 gid");

        // R5 flush at limit: six dead slots still count
        cfg_limit = 4'd7;
        fill(44'd50, 44'h650, 16'd3, 20'd3, 2'd1, 1, 0);
        look(44'd50, 12'h1, 16'd3, 20'd3, 1, 44'h650, 2'd1, "R5 before");
        fill(44'd51, 44'h651, 16'd3, 20'd3, 2'd2, 1, 0);
        look(44'd50, 12'h1, 16'd3, 20'd3, 0, 0, 0, "R5 flushed");
        look(44'd51, 12'h2, 16'd3, 20'd3, 1, 44'h651, 2'd2, "R5 new");

        // R11 same-cycle lookup sees invalidation
        fill(44'd52, 44'h652, 16'd2, 20'd2, 2'd3, 1, 0);
        @(negedge clk);
        inv_valid = 1; inv_gvma = 0; inv_gv = 0; inv_pscv = 0; inv_av = 0;
        look(44'd52, 12'h3, 16'd2, 20'd2, 0, 0, 0, "R11");
        @(negedge clk);
        inv_valid = 0;
        look(44'd52, 12'h3, 16'd2, 20'd2, 0, 0, 0, "R11 after");

        // R12 fill with invalidation in the same cycle
        @(negedge clk);
        inv_valid = 1; inv_gvma = 0; inv_gv = 0;
        fill_valid = 1; fill_ok = 1; fill_trap = 0;
        fill_vaddr = {44'd53, 12'h0}; fill_paddr = {44'h653, 12'h0};
        fill_gid = 16'd4; fill_pid = 20'd4; fill_perm = 2'd2;
        @(negedge clk);
        inv_valid = 0; fill_valid = 0;
        look(44'd53, 12'h4, 16'd4, 20'd4, 1, 44'h653, 2'd2, "R12");

        // R8 GVMA gv=0 kills all
        inv(1, 0, 0, 0, 16'd9, 20'd0, 56'h0, 0, "R8");
        look(44'd53, 12'h4, 16'd4, 20'd4, 0, 0, 0, "R8 all");

        // R4 zero limit
        cfg_limit = 4'd0;
        fill(44'd60, 44'h660, 16'd5, 20'd5, 2'd1, 1, 0);
        look(44'd60, 12'h0, 16'd5, 20'd5, 0, 0, 0, "R4");
        cfg_limit = 4'd8;
        fill(44'd60, 44'h660, 16'd5, 20'd5, 2'd1, 1, 0);
        look(44'd60, 12'h0, 16'd5, 20'd5, 1, 44'h660, 2'd1, "R4 re-enabled");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule